// File: doc/BRIEF.md
# Hysteretic PLL Digital Lock Detector

The block watches the UP and DOWN pulses that a phase frequency detector produces on every comparison cycle and keeps an active-high lock flag. A fast sampling clock measures the phase error of each cycle. That error is the number of sample periods during which either pulse is high. The measurement ends when both pulses have returned low.

The lock flag uses two thresholds. A tight acquire threshold applies while the loop is unlocked, and a run of consecutive tight cycles is needed before lock is declared. A precision input selects a run of three or five cycles. Once lock is declared, only a single cycle with an error above the wider release threshold clears it. Errors between the two thresholds leave lock in place, which gives hysteresis. Both thresholds are parameters counted in sample-clock periods, and the release threshold must be larger than the acquire threshold.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `lock_o` low and empties the run of good cycles. After reset, a full fresh run is needed before lock.
- R2: The error of one detector cycle is the count of sampled clock edges at which `up_i` or `dn_i` is high. Overlapping UP and DOWN time counts once. The cycle closes at the first edge where both inputs are sampled low.
- R3: With `precise_i` = 0 and lock low, `lock_o` rises at the edge that closes the third consecutive cycle whose error is below `ACQ_TICKS`.
- R4: With `precise_i` = 1 and lock low, `lock_o` rises at the edge that closes the fifth consecutive such cycle. Four are not enough.
- R5: While lock is low, a cycle whose error is `ACQ_TICKS` or more sets the run of good cycles back to zero.
- R6: While lock is high, a cycle whose error is at most `REL_TICKS` leaves lock high. This includes errors between `ACQ_TICKS` and `REL_TICKS`, and `REL_TICKS` itself.
- R7: While lock is high, a cycle whose error exceeds `REL_TICKS` clears lock at its closing edge. It also empties the run, so reacquiring lock needs a fresh full run.
- R8: Outside reset, `lock_o` changes only at an edge that closes a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | UP pulse from the phase detector |
| dn_i | input | 1 | DOWN pulse from the phase detector |
| precise_i | input | 1 | 0: three good cycles to lock, 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The assertions assume that `up_i` and `dn_i` are already synchronous to `clk`. They also assume that the union of the two pulses in one detector cycle is a single contiguous high stretch, so that each comparison closes exactly once. The stimulus satisfies this in three ways. It changes the inputs only on the falling clock edge. It always starts the DOWN pulse no later than the UP pulse ends. It separates detector cycles with several idle low samples. `precise_i` is changed only between runs, never in the middle of a measurement.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int ACQ_TICKS = 8,
  parameter int REL_TICKS = 13,
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic up_i,
  input  logic dn_i,
  input  logic precise_i,
  output logic lock_o
);
  localparam int WW = $clog2(REL_TICKS + 2);
  localparam int RW = $clog2(LONG_RUN + 1);
  localparam logic [WW-1:0] WMAX = '1;

  logic          busy_q;
  logic [WW-1:0] width_q;
  logic [RW-1:0] run_q;

  wire           err_now = up_i | dn_i;
  wire           close   = busy_q & ~err_now;
  wire           tight   = width_q < WW'(ACQ_TICKS);
  wire           slip    = width_q > WW'(REL_TICKS);
  wire [RW-1:0]  need    = precise_i ? RW'(LONG_RUN) : RW'(SHORT_RUN);
  wire [RW-1:0]  run_nx  = run_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      width_q <= '0;
      run_q   <= '0;
      lock_o  <= 1'b0;
    end else begin
      busy_q <= err_now;
      if (err_now)
        width_q <= (width_q == WMAX) ? width_q : width_q + 1'b1;
      else
        width_q <= '0;
      if (close) begin
        if (!lock_o) begin
          if (!tight) begin
            run_q <= '0;
          end else if (run_nx >= need) begin
            run_q  <= '0;
            lock_o <= 1'b1;
          end else begin
            run_q <= run_nx;
          end
        end else if (slip) begin
          lock_o <= 1'b0;
          run_q  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
  parameter int ACQ_TICKS = 8,
  parameter int REL_TICKS = 13
) (
  input logic clk,
  input logic rst,
  input logic up_i,
  input logic dn_i,
  input logic lock_o
);
  localparam int CW = $clog2(REL_TICKS + 2);
  logic          seen_q;
  logic [CW-1:0] cnt_q;
  wire           act = up_i | dn_i;
  wire           ends = seen_q & ~act;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= act;
      cnt_q  <= act ? ((cnt_q == '1) ? cnt_q : cnt_q + 1'b1) : '0;
    end
  end

  initial a_r7_threshold_order: assert (REL_TICKS > ACQ_TICKS);

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !lock_o);

  a_r8_rise_at_close: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> (!$past(act) && $past(seen_q)));

  a_r8_fall_at_close: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> ($past(rst) || (!$past(act) && $past(seen_q))));

  a_r6_mid_error_holds: assert property (@(posedge clk) disable iff (rst)
    (lock_o && ends && cnt_q <= CW'(REL_TICKS)) |=> lock_o);

  a_r7_wide_error_drops: assert property (@(posedge clk) disable iff (rst)
    (lock_o && ends && cnt_q > CW'(REL_TICKS)) |=> !lock_o);
endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
  .ACQ_TICKS(ACQ_TICKS), .REL_TICKS(REL_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .up_i(up_i), .dn_i(dn_i), .lock_o(lock_o)
);

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
  localparam int ACQ = 8;
  localparam int REL = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0, dn = 1'b0, prec = 1'b0;
  logic lock;

  int total = 0, bad = 0;
  int ref_run = 0;
  bit ref_lock = 1'b0;
  bit exp_q[$];
  string tag_q[$];
  event closed;

  always #10 clk = ~clk;

  pll_lock_monitor #(.ACQ_TICKS(ACQ), .REL_TICKS(REL)) u_dut (
    .clk(clk), .rst(rst), .up_i(up), .dn_i(dn), .precise_i(prec), .lock_o(lock)
  );

  task automatic check(string req, bit got, bit want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s lock=%0b expected=%0b", req, got, want);
    end
  endtask

  always begin
    @(closed);
    check(tag_q.pop_front(), lock, exp_q.pop_front());
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    ref_run = 0; ref_lock = 1'b0;
    check("R1", lock, 1'b0);
  endtask

  // UP high for u samples; DOWN high for d samples starting at dstart (<= u)
  task automatic pd_cycle(int u, int dstart, int d, string req);
    int w = (d > 0 && dstart + d > u) ? dstart + d : u;
    int need = prec ? 5 : 3;
    for (int t = 0; t < w; t++) begin
      @(negedge clk);
      up = (t < u);
      dn = (t >= dstart) && (t < dstart + d);
    end
    @(negedge clk); up = 1'b0; dn = 1'b0;
    if (!ref_lock) begin
      if (w < ACQ) begin
        ref_run++;
        if (ref_run >= need) begin ref_lock = 1'b1; ref_run = 0; end
      end else ref_run = 0;
    end else if (w > REL) begin
      ref_lock = 1'b0; ref_run = 0;
    end
    @(posedge clk);
    @(negedge clk);
    exp_q.push_back(ref_lock);
    tag_q.push_back(req);
    -> closed;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1", lock, 1'b0);
    do_reset();
    // R3: three tight cycles lock with precision low
    pd_cycle(4, 0, 0, "R3");
    pd_cycle(0, 0, 3, "R3");
    pd_cycle(7, 0, 0, "R3");
    // R6: mid errors and exactly REL keep lock
    pd_cycle(10, 0, 0, "R6");
    pd_cycle(5, 4, 9, "R6");
    // R7: one wide error drops lock
    pd_cycle(14, 0, 0, "R7");
    // R5: error at ACQ restarts the run
    pd_cycle(3, 0, 0, "R5");
    pd_cycle(3, 0, 0, "R5");
    pd_cycle(8, 0, 0, "R5");
    pd_cycle(3, 0, 0, "R5");
    pd_cycle(3, 0, 0, "R5");
    pd_cycle(3, 0, 0, "R5");
    // R2: overlapped pulses counted once: union 9 >= ACQ
    pd_cycle(20, 0, 0, "R7");
    pd_cycle(5, 3, 6, "R2");
    pd_cycle(4, 2, 3, "R2");
    pd_cycle(4, 0, 4, "R2");
    pd_cycle(2, 1, 6, "R2");
    // R1: reset mid run forces fresh run
    pd_cycle(20, 0, 0, "R7");
    pd_cycle(2, 0, 0, "R1");
    pd_cycle(2, 0, 0, "R1");
    do_reset();
    pd_cycle(2, 0, 0, "R1");
    pd_cycle(2, 0, 0, "R1");
    pd_cycle(2, 0, 0, "R1");
    // R4: precision high needs five
    pd_cycle(25, 0, 0, "R7");
    prec = 1'b1;
    for (int i = 0; i < 5; i++) pd_cycle(6, 0, 0, "R4");
    pd_cycle(13, 0, 0, "R6");
    pd_cycle(12, 10, 5, "R7");
    // R8: idle samples leave lock alone
    repeat (10) @(negedge clk);
    check("R8", lock, 1'b0);
    for (int i = 0; i < 4; i++) pd_cycle(1, 0, 1, "R4");
    repeat (10) @(negedge clk);
    check("R8", lock, 1'b0);
    pd_cycle(1, 0, 0, "R4");
    repeat (10) @(negedge clk);
    check("R8", lock, 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule